// File: doc/BRIEF.md
# Status-Polled Flash Bank Erase and Program Sequencer

This block rewrites one bank of a byte-wide command/status flash from a source buffer. A single start pulse runs the whole job. The block first erases the bank and reads it back to confirm that every byte is blank. It then programs the bank one byte at a time, fetching each byte from the source buffer port. Last, it reads the bank back and compares every byte with the buffer.

Every erase or program operation is followed by status polling. The block writes a status-request command to the bank base and reads the base on the next cycle. It repeats this until the ready bit comes up or a poll limit is reached. After each operation it writes clear-status and then reset commands. The flash bus is a simple one-cycle write strobe and a one-cycle read strobe. Read data is taken in the same cycle as the read strobe.

At the end the block raises done for one cycle. Three flags report the result: timeout, verify failure, and an error bit seen in the status. The flags hold until the next start.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset the block is idle: busy, done, both strobes, timeout, verify_fail and status_err are all low.
- R2: A start pulse while idle begins the job. On the next two cycles the block writes 0x20 and then 0xD0 to address 0. A start pulse while busy has no effect on the bus sequence.
- R3: Each poll is a write of 0x70 to address 0, followed on the next cycle by a read of address 0. The operation is complete when bit 7 of the value read is set. Otherwise the next poll follows at once.
- R4: Each byte is programmed as follows. The block writes 0x40 to the byte's address and then holds the bus idle for DELAY_CYC cycles. It then writes the source byte for that address to the same address and polls. Bytes go in ascending address order, starting from 0.
- R5: An operation that has not completed after POLL_MAX status reads sets timeout. A timeout during programming skips all remaining bytes.
- R6: After the erase operation, and after the program phase ends (by completion or timeout), the block writes 0x50 and then 0xFF to address 0.
- R7: After the erase epilogue the block reads addresses in ascending order and compares each byte with 0xFF. The first byte that differs sets verify_fail and ends the job without programming.
- R8: After the program epilogue the block reads addresses in ascending order and compares each byte with the source byte for that address. The first mismatch sets verify_fail and ends the job.
- R9: Any status read with a nonzero value under mask 0x38 (bits 5 to 3) sets status_err.
- R10: At the end of the job, done is high for exactly one cycle and the block then returns to idle. timeout, verify_fail and status_err hold their values while idle and are cleared by the next start.
- R11: The write strobe and the read strobe are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin erase, program and verify (accepted only while idle) |
| src_addr | output | AW | Address into the source buffer |
| src_data | input | 8 | Source byte at src_addr, valid in the same cycle |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_addr | output | AW | Flash byte address within the bank |
| fl_wdata | output | 8 | Command or data byte for a write |
| fl_rdata | input | 8 | Flash read data, valid in the same cycle as fl_re |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse at the end of a job |
| timeout | output | 1 | A status poll loop ran out |
| verify_fail | output | 1 | Read-back after erase or program mismatched |
| status_err | output | 1 | An error bit was seen in a status read |

## Verification
Some properties are checked on every cycle:
- The two strobes are exclusive.
- A start accepted while idle leads straight to the erase setup write.
- Every new read burst is preceded by a status-request or reset write to the base.
- done is a single-cycle pulse that returns the block to idle.
- The result flags stay still while idle.

Other behaviour only the bench scenarios can show. This includes the exact order of command, wait, data and poll cycles across a whole bank, and the points at which a timeout or the first mismatch cuts the job short. It also includes whether the flags match what a stub flash with injected stuck bytes, hung operations and error status should produce.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ERS_SETUP,
        ST_ERS_GO,
        ST_POLL_CMD,
        ST_POLL_RD,
        ST_CLR,
        ST_RST,
        ST_CHECK,
        ST_PGM_SETUP,
        ST_PGM_WAIT,
        ST_PGM_DATA,
        ST_FINISH
    } seq_state_e;

    localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
    localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
    localparam logic [7:0] CMD_STATUS      = 8'h70;
    localparam logic [7:0] CMD_PGM_SETUP   = 8'h40;
    localparam logic [7:0] CMD_CLR_STATUS  = 8'h50;
    localparam logic [7:0] CMD_RESET       = 8'hFF;

    localparam int         STAT_READY_BIT  = 7;
    localparam logic [7:0] STAT_ERR_MASK   = 8'h38;
    localparam logic [7:0] BLANK_BYTE      = 8'hFF;

endpackage

// File: rtl/flash_prog_cnt.sv
// Counter with a clear and an increment input.
// hit is high when LIMIT counts have been taken (count equals LIMIT-1).
module flash_prog_cnt #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic hit
);
    localparam int unsigned W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign hit = (cnt_q == W'(LIMIT - 1));
endmodule

// File: rtl/flash_prog_bus.sv
// Decodes the sequencer state into flash bus strobes, address and write byte.
module flash_prog_bus
    import flash_prog_pkg::*;
#(
    parameter int AW = 13
) (
    input  seq_state_e      state,
    input  logic [AW-1:0]   cur_addr,
    input  logic [7:0]      src_byte,
    output logic            we,
    output logic            re,
    output logic [AW-1:0]   addr,
    output logic [7:0]      wdata
);
    always_comb begin
        we    = 1'b0;
        re    = 1'b0;
        addr  = '0;
        wdata = '0;
        unique case (state)
            ST_ERS_SETUP: begin we = 1'b1; wdata = CMD_ERASE_SETUP; end
            ST_ERS_GO:    begin we = 1'b1; wdata = CMD_ERASE_GO;    end
            ST_POLL_CMD:  begin we = 1'b1; wdata = CMD_STATUS;      end
            ST_POLL_RD:   begin re = 1'b1;                          end
            ST_CLR:       begin we = 1'b1; wdata = CMD_CLR_STATUS;  end
            ST_RST:       begin we = 1'b1; wdata = CMD_RESET;       end
            ST_CHECK:     begin re = 1'b1; addr = cur_addr;         end
            ST_PGM_SETUP: begin we = 1'b1; addr = cur_addr; wdata = CMD_PGM_SETUP; end
            ST_PGM_DATA:  begin we = 1'b1; addr = cur_addr; wdata = src_byte;      end
            default: ;
        endcase
    end
endmodule

// File: rtl/flash_prog_seq.sv
// Erase / program / verify sequencer for one bank of a command-status flash.
module flash_prog_seq
    import flash_prog_pkg::*;
#(
    parameter int AW        = 13,
    parameter int DELAY_CYC = 50,
    parameter int POLL_MAX  = 1000000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic [AW-1:0] src_addr,
    input  logic [7:0]    src_data,
    output logic          fl_we,
    output logic          fl_re,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_wdata,
    input  logic [7:0]    fl_rdata,
    output logic          busy,
    output logic          done,
    output logic          timeout,
    output logic          verify_fail,
    output logic          status_err
);
    localparam logic [AW-1:0] LAST_ADDR = '1;

    typedef struct packed {
        seq_state_e    state;
        logic [AW-1:0] addr;
        logic          pgm;    // 0: erase phase, 1: program phase
        logic          tmo;
        logic          vfail;
        logic          err;
    } regs_t;

    localparam regs_t REGS_RST = '{state: ST_IDLE, addr: '0, pgm: 1'b0,
                                   tmo: 1'b0, vfail: 1'b0, err: 1'b0};

    regs_t r_d, r_q;
    logic  poll_hit, dly_hit;
    logic  stat_ready;
    logic  [7:0] expect_byte;

    flash_prog_cnt #(.LIMIT(POLL_MAX)) u_poll_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (r_q.state != ST_POLL_CMD && r_q.state != ST_POLL_RD),
        .inc   (r_q.state == ST_POLL_RD),
        .hit   (poll_hit)
    );

    flash_prog_cnt #(.LIMIT(DELAY_CYC)) u_dly_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (r_q.state != ST_PGM_WAIT),
        .inc   (r_q.state == ST_PGM_WAIT),
        .hit   (dly_hit)
    );

    flash_prog_bus #(.AW(AW)) u_bus (
        .state    (r_q.state),
        .cur_addr (r_q.addr),
        .src_byte (src_data),
        .we       (fl_we),
        .re       (fl_re),
        .addr     (fl_addr),
        .wdata    (fl_wdata)
    );

    assign stat_ready  = fl_rdata[STAT_READY_BIT];
    assign expect_byte = r_q.pgm ? src_data : BLANK_BYTE;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d       = REGS_RST;
                    r_d.state = ST_ERS_SETUP;
                end
            end
            ST_ERS_SETUP: r_d.state = ST_ERS_GO;
            ST_ERS_GO:    r_d.state = ST_POLL_CMD;
            ST_POLL_CMD:  r_d.state = ST_POLL_RD;
            ST_POLL_RD: begin
                if ((fl_rdata & STAT_ERR_MASK) != 8'h00)
                    r_d.err = 1'b1;
                if (stat_ready) begin
                    if (r_q.pgm && r_q.addr != LAST_ADDR) begin
                        r_d.addr  = r_q.addr + 1'b1;
                        r_d.state = ST_PGM_SETUP;
                    end else begin
                        r_d.state = ST_CLR;
                    end
                end else if (poll_hit) begin
                    r_d.tmo   = 1'b1;
                    r_d.state = ST_CLR;
                end else begin
                    r_d.state = ST_POLL_CMD;
                end
            end
            ST_CLR: r_d.state = ST_RST;
            ST_RST: begin
                r_d.addr  = '0;
                r_d.state = ST_CHECK;
            end
            ST_CHECK: begin
                if (fl_rdata != expect_byte) begin
                    r_d.vfail = 1'b1;
                    r_d.state = ST_FINISH;
                end else if (r_q.addr == LAST_ADDR) begin
                    if (!r_q.pgm) begin
                        r_d.pgm   = 1'b1;
                        r_d.addr  = '0;
                        r_d.state = ST_PGM_SETUP;
                    end else begin
                        r_d.state = ST_FINISH;
                    end
                end else begin
                    r_d.addr = r_q.addr + 1'b1;
                end
            end
            ST_PGM_SETUP: r_d.state = ST_PGM_WAIT;
            ST_PGM_WAIT:  if (dly_hit) r_d.state = ST_PGM_DATA;
            ST_PGM_DATA:  r_d.state = ST_POLL_CMD;
            ST_FINISH:    r_d.state = ST_IDLE;
            default:      r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= REGS_RST;
        else
            r_q <= r_d;
    end

    assign src_addr    = r_q.addr;
    assign busy        = (r_q.state != ST_IDLE);
    assign done        = (r_q.state == ST_FINISH);
    assign timeout     = r_q.tmo;
    assign verify_fail = r_q.vfail;
    assign status_err  = r_q.err;
endmodule

// File: rtl/flash_prog_chk.sv
module flash_prog_chk #(
    parameter int AW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          fl_we,
    input logic          fl_re,
    input logic [AW-1:0] fl_addr,
    input logic [7:0]    fl_wdata,
    input logic          timeout,
    input logic          verify_fail,
    input logic          status_err
);
    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we && fl_re));

    assert_start_erase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (fl_we && fl_wdata == 8'h20 && fl_addr == '0));

    assert_read_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_re) |-> ($past(fl_we) && $past(fl_addr) == '0 &&
                          ($past(fl_wdata) == 8'h70 || $past(fl_wdata) == 8'hFF)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(timeout) && $stable(verify_fail) && $stable(status_err)));

    assert_timeout_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> busy);
endmodule

bind flash_prog_seq flash_prog_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .fl_we       (fl_we),
    .fl_re       (fl_re),
    .fl_addr     (fl_addr),
    .fl_wdata    (fl_wdata),
    .timeout     (timeout),
    .verify_fail (verify_fail),
    .status_err  (status_err)
);

// File: tb/flash_prog_seq_bench.sv
module flash_prog_seq_bench;
    localparam int AW   = 5;
    localparam int N    = 1 << AW;
    localparam int DLY  = 3;
    localparam int PMAX = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] src_addr, fl_addr;
    logic [7:0] src_data, fl_wdata, fl_rdata;
    logic fl_we, fl_re, busy, done, timeout, verify_fail, status_err;

    always #10 clk = ~clk;

    flash_prog_seq #(.AW(AW), .DELAY_CYC(DLY), .POLL_MAX(PMAX)) u_flash_prog_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_addr(src_addr), .src_data(src_data),
        .fl_we(fl_we), .fl_re(fl_re), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_rdata(fl_rdata), .busy(busy), .done(done), .timeout(timeout),
        .verify_fail(verify_fail), .status_err(status_err)
    );

    // ---------------- scenario knobs and source buffer ----------------
    int         busy_polls;
    logic [7:0] err_bits;
    bit         hang_erase;
    int         hang_addr;
    int         stuck_mode;   // 0 none, 1 stuck after erase, 2 program write lost
    int         stuck_a;
    logic [7:0] stuck_v;
    logic [7:0] src [N];

    assign src_data = src[src_addr];

    // ---------------- flash stub ----------------
    logic [7:0] mem [N];
    logic stat_mode, pend_pgm, ers_armed, op_hang;
    int   rd_cnt;

    always_comb begin
        if (stat_mode)
            fl_rdata = {(!op_hang && rd_cnt >= busy_polls), 7'b0} | err_bits;
        else
            fl_rdata = mem[fl_addr];
    end

    always @(posedge clk) begin
        if (fl_re && stat_mode) rd_cnt <= rd_cnt + 1;
        if (fl_we) begin
            if (pend_pgm) begin
                pend_pgm <= 1'b0;
                if (!(stuck_mode == 2 && int'(fl_addr) == stuck_a)) mem[fl_addr] <= fl_wdata;
                rd_cnt  <= 0;
                op_hang <= (int'(fl_addr) == hang_addr);
            end else begin
                case (fl_wdata)
                    8'h20: ers_armed <= 1'b1;
                    8'hD0: if (ers_armed) begin
                        ers_armed <= 1'b0;
                        for (int i = 0; i < N; i++)
                            mem[i] <= (stuck_mode == 1 && i == stuck_a) ? stuck_v : 8'hFF;
                        rd_cnt  <= 0;
                        op_hang <= hang_erase;
                    end
                    8'h40: pend_pgm  <= 1'b1;
                    8'h70: stat_mode <= 1'b1;
                    8'hFF: stat_mode <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    // ---------------- behavioural reference model ----------------
    typedef struct {
        bit    we;
        bit    re;
        int    addr;
        int    wd;
        bit    dn;
        string tag;
    } ev_t;

    ev_t        evq [$];
    logic [7:0] mm [N];
    bit exp_tmo, exp_vf, exp_err;

    function automatic void push(bit we, bit re, int addr, int wd, bit dn, string tag);
        ev_t e;
        e.we = we; e.re = re; e.addr = addr; e.wd = wd; e.dn = dn; e.tag = tag;
        evq.push_back(e);
    endfunction

    function automatic bit mpoll(bit hang);
        for (int n = 0; n < PMAX; n++) begin
            push(1, 0, 0, 'h70, 0, "R3");
            push(0, 1, 0, 0, 0, "R3");
            if (!hang && n >= busy_polls) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic void build_model();
        bit fail;
        evq.delete();
        exp_tmo = 0; exp_vf = 0;
        exp_err = (err_bits & 8'h38) != 0;
        push(1, 0, 0, 'h20, 0, "R2");
        push(1, 0, 0, 'hD0, 0, "R2");
        if (!mpoll(hang_erase)) exp_tmo = 1;
        push(1, 0, 0, 'h50, 0, "R6");
        push(1, 0, 0, 'hFF, 0, "R6");
        for (int i = 0; i < N; i++) mm[i] = (stuck_mode == 1 && i == stuck_a) ? stuck_v : 8'hFF;
        fail = 0;
        for (int a = 0; a < N; a++) begin
            push(0, 1, a, 0, 0, "R7");
            if (mm[a] != 8'hFF) begin fail = 1; break; end
        end
        if (fail) exp_vf = 1;
        else begin
            for (int a = 0; a < N; a++) begin
                push(1, 0, a, 'h40, 0, "R4");
                for (int d = 0; d < DLY; d++) push(0, 0, 0, 0, 0, "R4");
                push(1, 0, a, int'(src[a]), 0, "R4");
                if (!(stuck_mode == 2 && a == stuck_a)) mm[a] = src[a];
                if (!mpoll(a == hang_addr)) begin exp_tmo = 1; break; end
            end
            push(1, 0, 0, 'h50, 0, "R6");
            push(1, 0, 0, 'hFF, 0, "R6");
            for (int a = 0; a < N; a++) begin
                push(0, 1, a, 0, 0, "R8");
                if (mm[a] != src[a]) begin exp_vf = 1; break; end
            end
        end
        push(0, 0, 0, 0, 1, "R10");
    endfunction

    // ---------------- checking ----------------
    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic run_case(int inject_k);
        ev_t e;
        int  k;
        build_model();
        @(negedge clk);
        start = 1'b1;
        k = 0;
        while (evq.size() > 0) begin
            @(negedge clk);
            start = (k == inject_k);
            e = evq.pop_front();
            chk(busy == 1'b1, e.tag, "busy", busy, 1);
            chk(done == e.dn, e.tag, "done", done, e.dn);
            chk(fl_we == e.we, e.tag, "we", fl_we, e.we);
            chk(fl_re == e.re, e.tag, "re", fl_re, e.re);
            chk(!(fl_we && fl_re), "R11", "strobe overlap", int'(fl_we & fl_re), 0);
            if (e.we || e.re) chk(int'(fl_addr) == e.addr, e.tag, "addr", fl_addr, e.addr);
            if (e.we) chk(int'(fl_wdata) == e.wd, e.tag, "wdata", fl_wdata, e.wd);
            if (k == 0) chk({timeout, verify_fail, status_err} == 3'b000, "R10",
                            "flags after start", {timeout, verify_fail, status_err}, 0);
            if (e.dn) begin
                chk(timeout == exp_tmo, "R5", "timeout", timeout, exp_tmo);
                chk(verify_fail == exp_vf, stuck_mode == 1 ? "R7" : "R8",
                    "verify_fail", verify_fail, exp_vf);
                chk(status_err == exp_err, "R9", "status_err", status_err, exp_err);
            end
            k++;
        end
        @(negedge clk);
        start = 1'b0;
        chk(!busy && !done, "R10", "idle after done", {busy, done}, 0);
        @(negedge clk);
        chk({timeout, verify_fail, status_err} == {exp_tmo, exp_vf, exp_err}, "R10",
            "flags held", {timeout, verify_fail, status_err}, {exp_tmo, exp_vf, exp_err});
    endtask

    task automatic defaults();
        busy_polls = 2; err_bits = 8'h00; hang_erase = 0; hang_addr = -1;
        stuck_mode = 0; stuck_a = 0; stuck_v = 8'h00;
    endtask

    initial begin
        defaults();
        stat_mode = 0; pend_pgm = 0; ers_armed = 0; op_hang = 0; rd_cnt = 0;
        for (int i = 0; i < N; i++) begin
            mem[i] = 8'h00;
            src[i] = 8'(i * 37 + 5);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        chk({busy, done, fl_we, fl_re, timeout, verify_fail, status_err} == 7'b0, "R1",
            "reset state", {busy, done, fl_we, fl_re, timeout, verify_fail, status_err}, 0);

        // R2 (start ignored while busy), R3, R4, R6, R8: clean run
        defaults();
        run_case(40);

        // R9: error bits in status, ready at first poll
        defaults(); busy_polls = 0; err_bits = 8'h10;
        run_case(-1);

        // R7: a byte stays at 0x00 after erase
        defaults(); stuck_mode = 1; stuck_a = 9; stuck_v = 8'h00;
        run_case(-1);

        // R8: write to byte 12 is lost
        defaults(); stuck_mode = 2; stuck_a = 12;
        run_case(-1);

        // R5: program of byte 4 never completes
        defaults(); hang_addr = 4;
        run_case(-1);

        // R5 and R10: erase completes but never reports ready; flags cleared by start
        defaults(); hang_erase = 1;
        run_case(-1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule